// File: doc/BRIEF.md
# Floating-Point Status Word and Condition-Code Unit

This block owns the 16-bit status register of a floating-point stack unit. Single-cycle opcode strobes from the instruction sequencer move the condition-code bits. The sequencer supplies operand classification (sign, zero, empty tag) and the low three quotient bits of a partial remainder from outside. Other strobes wipe the low byte, reset the whole register, or restore a saved image.

The stack-top pointer is not held in the register. It is supplied live on `top_i` and merged into bits 13:11 whenever the word is presented. A store strobe snapshots that presented word into a register for the memory write path. When a saved image is restored, its stack-top field is passed back out with a one-cycle valid, so the pointer owner can reload it.

Condition codes sit at fixed positions: C0 at bit 8, C1 at bit 9, C2 at bit 10 and C3 at bit 14.

Top module: `fpu_status_unit`

## Requirements
- R1: After reset, the stored register is 0, `store_data_o` is 0 and `load_top_vld_o` is 0.
- R2: `status_o` equals the stored register ANDed with 0xC7FF, ORed with `top_i` placed in bits 13:11. It follows `top_i` in the same cycle.
- R3: Clear-exceptions (`op_clear_i`) keeps bits 15:8 and zeroes bits 7:0.
- R4: Test-against-zero (`op_test_i`) zeroes C0, C2 and C3. It then sets C3 if `opnd_zero_i` is high; otherwise it sets C0 if `opnd_neg_i` is high. All other bits are kept.
- R5: Examine (`op_exam_i`) zeroes C0 to C3. If `tag_empty_i` is high it sets C0 and C3. Otherwise it sets C3 when zero, or C2 when not zero. Independently, C1 is set equal to `opnd_neg_i`.
- R6: Partial remainder (`op_rem_i`) zeroes C0 to C3, then sets C0 = `quot_i[2]`, C3 = `quot_i[1]` and C1 = `quot_i[0]`.
- R7: Reduction-complete (`op_trig_i`) zeroes C2 only.
- R8: Initialise (`op_init_i`) sets the register to 0.
- R9: Restore (`op_load_i`) stores all 16 bits of `load_data_i`. On the following cycle, `load_top_vld_o` is 1 for exactly one cycle, with `load_top_o` equal to `load_data_i[13:11]`.
- R10: When several update strobes are high together, only the highest-priority one acts. Priority from highest to lowest is init, load, clear, test, examine, remainder, reduction-complete.
- R11: `op_store_i` captures the word presented in that cycle (pre-update register, current `top_i`) into `store_data_o`. It does this regardless of any update strobe in the same cycle.
- R12: With no update strobe high, the register holds its value.
- R13: All register updates appear on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_init_i | input | 1 | Initialise strobe |
| op_load_i | input | 1 | Restore saved word strobe |
| op_clear_i | input | 1 | Clear-exceptions strobe |
| op_test_i | input | 1 | Test-against-zero strobe |
| op_exam_i | input | 1 | Examine strobe |
| op_rem_i | input | 1 | Partial-remainder strobe |
| op_trig_i | input | 1 | Reduction-complete strobe |
| op_store_i | input | 1 | Snapshot presented word |
| load_data_i | input | 16 | Saved status image |
| opnd_neg_i | input | 1 | Operand is negative |
| opnd_zero_i | input | 1 | Operand is zero |
| tag_empty_i | input | 1 | Top register tagged empty |
| quot_i | input | 3 | Low quotient bits |
| top_i | input | 3 | Current stack-top pointer |
| status_o | output | 16 | Composed status word |
| store_data_o | output | 16 | Snapshot of composed word |
| load_top_o | output | 3 | Stack-top field of restored word |
| load_top_vld_o | output | 1 | load_top_o valid pulse |

## Verification
A snapshot and an update can land in the same cycle. So can two or more update strobes. Random stimulus raises each strobe independently with modest probability, so both collisions occur often. Directed cases also force init with load, and store with restore. The bench keeps a reference register: every snapshot must show the pre-edge composed word, and every collision must follow the priority order alone.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int SW_W    = 16;
  localparam int TOP_W   = 3;
  localparam int TOP_LSB = 11;
  localparam int C0_B    = 8;
  localparam int C1_B    = 9;
  localparam int C2_B    = 10;
  localparam int C3_B    = 14;
  localparam int Q_W     = 3;
  // strobe index = priority (lower wins)
  localparam int OP_INIT  = 0;
  localparam int OP_LOAD  = 1;
  localparam int OP_CLEAR = 2;
  localparam int OP_TEST  = 3;
  localparam int OP_EXAM  = 4;
  localparam int OP_REM   = 5;
  localparam int OP_TRIG  = 6;
  localparam int N_OPS    = 7;
  localparam logic [SW_W-1:0] TOP_MASK =
    ~(SW_W'((1 << TOP_W) - 1) << TOP_LSB);
endpackage

// File: rtl/fsw_prio.sv
module fsw_prio #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end

  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/fsw_next.sv
module fsw_next
  import fsw_pkg::*;
(
  input  logic [SW_W-1:0]  sw_i,
  input  logic [N_OPS-1:0] gnt_i,
  input  logic [SW_W-1:0]  load_data_i,
  input  logic             neg_i,
  input  logic             zero_i,
  input  logic             empty_i,
  input  logic [Q_W-1:0]   quot_i,
  output logic [SW_W-1:0]  sw_o
);
  always_comb begin
    sw_o = sw_i;
    if (gnt_i[OP_INIT]) begin
      sw_o = '0;
    end else if (gnt_i[OP_LOAD]) begin
      sw_o = load_data_i;
    end else if (gnt_i[OP_CLEAR]) begin
      sw_o[7:0] = '0;
    end else if (gnt_i[OP_TEST]) begin
      sw_o[C0_B] = ~zero_i & neg_i;
      sw_o[C2_B] = 1'b0;
      sw_o[C3_B] = zero_i;
    end else if (gnt_i[OP_EXAM]) begin
      sw_o[C0_B] = empty_i;
      sw_o[C1_B] = neg_i;
      sw_o[C2_B] = ~empty_i & ~zero_i;
      sw_o[C3_B] = empty_i | zero_i;
    end else if (gnt_i[OP_REM]) begin
      sw_o[C0_B] = quot_i[2];
      sw_o[C1_B] = quot_i[0];
      sw_o[C2_B] = 1'b0;
      sw_o[C3_B] = quot_i[1];
    end else if (gnt_i[OP_TRIG]) begin
      sw_o[C2_B] = 1'b0;
    end
  end
endmodule

// File: rtl/fsw_read.sv
module fsw_read
  import fsw_pkg::*;
(
  input  logic [SW_W-1:0]  sw_i,
  input  logic [TOP_W-1:0] top_i,
  output logic [SW_W-1:0]  status_o
);
  assign status_o = (sw_i & TOP_MASK) | (SW_W'(top_i) << TOP_LSB);

  always_comb begin
    p_top_field_r2: assert (status_o[TOP_LSB +: TOP_W] == top_i);
  end
endmodule

// File: rtl/fpu_status_unit.sv
module fpu_status_unit
  import fsw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_init_i,
  input  logic             op_load_i,
  input  logic             op_clear_i,
  input  logic             op_test_i,
  input  logic             op_exam_i,
  input  logic             op_rem_i,
  input  logic             op_trig_i,
  input  logic             op_store_i,
  input  logic [SW_W-1:0]  load_data_i,
  input  logic             opnd_neg_i,
  input  logic             opnd_zero_i,
  input  logic             tag_empty_i,
  input  logic [Q_W-1:0]   quot_i,
  input  logic [TOP_W-1:0] top_i,
  output logic [SW_W-1:0]  status_o,
  output logic [SW_W-1:0]  store_data_o,
  output logic [TOP_W-1:0] load_top_o,
  output logic             load_top_vld_o
);
  logic [N_OPS-1:0] req, gnt;
  logic [SW_W-1:0]  sw_q, sw_d, rd_word;
  logic [TOP_W-1:0] ltop_q;
  logic             ltop_vld_q;
  logic [SW_W-1:0]  store_q;

  always_comb begin
    req           = '0;
    req[OP_INIT]  = op_init_i;
    req[OP_LOAD]  = op_load_i;
    req[OP_CLEAR] = op_clear_i;
    req[OP_TEST]  = op_test_i;
    req[OP_EXAM]  = op_exam_i;
    req[OP_REM]   = op_rem_i;
    req[OP_TRIG]  = op_trig_i;
  end

  fsw_prio #(.N(N_OPS)) u_prio (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .gnt_o (gnt)
  );

  fsw_next u_next (
    .sw_i       (sw_q),
    .gnt_i      (gnt),
    .load_data_i(load_data_i),
    .neg_i      (opnd_neg_i),
    .zero_i     (opnd_zero_i),
    .empty_i    (tag_empty_i),
    .quot_i     (quot_i),
    .sw_o       (sw_d)
  );

  fsw_read u_read (
    .sw_i    (sw_q),
    .top_i   (top_i),
    .status_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q       <= '0;
      store_q    <= '0;
      ltop_q     <= '0;
      ltop_vld_q <= 1'b0;
    end else begin
      sw_q       <= sw_d;
      ltop_vld_q <= gnt[OP_LOAD];
      if (gnt[OP_LOAD]) ltop_q <= load_data_i[TOP_LSB +: TOP_W];
      if (op_store_i)   store_q <= rd_word;
    end
  end

  assign status_o       = rd_word;
  assign store_data_o   = store_q;
  assign load_top_o     = ltop_q;
  assign load_top_vld_o = ltop_vld_q;

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req) |=> $stable(sw_q));
  p_init_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_init_i |=> (sw_q == '0));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_clear_i && !op_init_i && !op_load_i)
      |=> (sw_q[7:0] == '0) && (sw_q[15:8] == $past(sw_q[15:8])));
  p_exam_c1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_exam_i && !(|req[OP_EXAM-1:0])) |=> (sw_q[C1_B] == $past(opnd_neg_i)));
  p_load_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_load_i && !op_init_i)
      |=> load_top_vld_o && (load_top_o == $past(load_data_i[TOP_LSB +: TOP_W])));
  p_store_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_store_i |=> (store_data_o == $past(status_o)));
endmodule

// File: tb/fpu_status_unit_tb.sv
`timescale 1ns/100ps
module fpu_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ops = '0;   // bit i = priority i: init,load,clear,test,exam,rem,trig
  logic        store = 1'b0;
  logic [15:0] ld = '0;
  logic        neg = 1'b0, zero = 1'b0, empty = 1'b0;
  logic [2:0]  quot = '0, top = '0;
  logic [15:0] status, snap;
  logic [2:0]  ltop;
  logic        ltop_vld;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] sw_m = '0, snap_m = '0;

  always #2.5 clk = ~clk;

  fpu_status_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .op_init_i(ops[0]), .op_load_i(ops[1]), .op_clear_i(ops[2]),
    .op_test_i(ops[3]), .op_exam_i(ops[4]), .op_rem_i(ops[5]),
    .op_trig_i(ops[6]), .op_store_i(store), .load_data_i(ld),
    .opnd_neg_i(neg), .opnd_zero_i(zero), .tag_empty_i(empty),
    .quot_i(quot), .top_i(top),
    .status_o(status), .store_data_o(snap),
    .load_top_o(ltop), .load_top_vld_o(ltop_vld)
  );

  function automatic logic [15:0] compose(logic [15:0] s, logic [2:0] t);
    return (s & 16'hC7FF) | {2'b00, t, 11'b0};
  endfunction

  function automatic logic [15:0] model_next(logic [15:0] s, logic [6:0] o,
      logic [15:0] d, logic n, logic z, logic e, logic [2:0] q);
    logic [15:0] r = s;
    if (o[0]) r = '0;
    else if (o[1]) r = d;
    else if (o[2]) r[7:0] = 8'h00;
    else if (o[3]) begin
      r[8] = 0; r[10] = 0; r[14] = 0;
      if (z) r[14] = 1; else if (n) r[8] = 1;
    end else if (o[4]) begin
      r[8] = 0; r[9] = 0; r[10] = 0; r[14] = 0;
      if (e) begin r[8] = 1; r[14] = 1; end
      else if (z) r[14] = 1;
      else r[10] = 1;
      if (n) r[9] = 1;
    end else if (o[5]) begin
      r[8] = q[2]; r[14] = q[1]; r[9] = q[0]; r[10] = 0;
    end else if (o[6]) r[10] = 0;
    return r;
  endfunction

  function automatic string req_of(logic [6:0] o);
    if ($countones(o) > 1) return "R10";
    case (o)
      7'b0000001: return "R8";
      7'b0000010: return "R9";
      7'b0000100: return "R3";
      7'b0001000: return "R4";
      7'b0010000: return "R5";
      7'b0100000: return "R6";
      7'b1000000: return "R7";
      default:    return "R12";
    endcase
  endfunction

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compute model, check just after the edge (R13)
  task automatic step();
    logic [15:0] nxt;
    logic        ld_won;
    nxt    = model_next(sw_m, ops, ld, neg, zero, empty, quot);
    ld_won = ops[1] && !ops[0];
    if (store) snap_m = compose(sw_m, top);
    @(posedge clk); #1;
    sw_m = nxt;
    chk(req_of(ops), status, compose(sw_m, top));
    chk("R11", snap, snap_m);
    chk("R9", {15'b0, ltop_vld}, {15'b0, ld_won});
    if (ld_won) chk("R9", {13'b0, ltop}, {13'b0, ld[13:11]});
    @(negedge clk);
    ops = '0; store = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", status, 16'h0000);
    chk("R1", snap, 16'h0000);
    chk("R1", {15'b0, ltop_vld}, 16'h0);
    rst_n = 1;
    @(negedge clk);

    // R9 full restore, R2 top merge
    ops = 7'b0000010; ld = 16'hFFFF; top = 3'd0; step();
    chk("R2", status, 16'hC7FF);
    top = 3'd5; #1; chk("R2", status, 16'hEFFF);
    // R12 idle cycle: load pulse must drop
    step();
    // R3 clear
    ops = 7'b0000100; step();
    chk("R3", status & 16'hC7FF, 16'hC700);
    // R5 examine empty and negative: C0,C1,C3
    ops = 7'b0010000; empty = 1; neg = 1; zero = 0; step();
    chk("R5", status & 16'h4700, 16'h4300);
    // R4 zero and negative: only C3
    ops = 7'b0001000; empty = 0; zero = 1; neg = 1; step();
    chk("R4", status & 16'h4500, 16'h4000);
    // R6 quotient 5: C0 and C1
    ops = 7'b0100000; quot = 3'd5; step();
    chk("R6", status & 16'h4700, 16'h0300);
    // R7
    ops = 7'b0010000; empty = 0; zero = 0; neg = 0; step();
    ops = 7'b1000000; step();
    chk("R7", {15'b0, status[10]}, 16'h0);
    // R10 init beats load, R11 snapshot sees pre-update word
    ops = 7'b0000011; ld = 16'h1234; store = 1; top = 3'd2; step();
    chk("R10", status, compose(16'h0000, 3'd2));
    // R11 store with restore same cycle
    ops = 7'b0000010; ld = 16'hA5A5; store = 1; step();

    for (int i = 0; i < 1500; i++) begin
      for (int b = 0; b < 7; b++) ops[b] = ($urandom % 7) == 0;
      store = ($urandom % 4) == 0;
      ld    = 16'($urandom);
      neg   = 1'($urandom); zero = 1'($urandom); empty = 1'($urandom);
      quot  = 3'($urandom); top  = 3'($urandom);
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule